// File: doc/BRIEF.md
# Micro-op Condition Test Evaluator

This block decides whether a conditional micro-op takes effect. It takes a processor flag word and a 5-bit condition selector, and it returns one predicate bit. The selector space is split into two halves on bit 4. Each upper-half code is the logical inverse of the lower-half code with the same low four bits, with one exception at position 7. There, the upper code tests for a string loop that ends with neither zero flag set.

The block tests the architectural carry, parity, zero, sign and overflow flags. It also tests two emulation flags, an extra carry and an extra zero. Compound tests cover unsigned below-or-equal, signed less-than, signed less-or-equal and string-loop termination. Three string codes in each half are reserved. Selecting one of them raises an illegal output and forces the predicate high. Both outputs are registered, so the result for the inputs sampled at one rising edge appears right after that edge.

Top module: `cond_test_eval`

## Requirements
- R1: While `rst` is high at a rising edge, `pred_o` and `illegal_o` are 0 after that edge.
- R2: Outputs appear one clock after the inputs they depend on are sampled (one register stage).
- R3: Code 0 yields predicate 1 and code 16 yields predicate 0, whatever the flags.
- R4: Single-flag codes return one flag, and their upper-half partners (code + 16) return its inverse. The pairs are code 1 = extra carry (flag bit 12), 2 = extra zero (bit 13), 8 = overflow (bit 11), 9 = carry (bit 0), 10 = zero (bit 6), 12 = sign (bit 7) and 13 = parity (bit 2).
- R5: Code 3 returns NOT(NOT extra-zero AND zero), and code 19 returns (NOT extra-zero AND zero).
- R6: Code 7 returns (NOT extra-zero AND zero), and code 23 returns (NOT extra-zero AND NOT zero).
- R7: Code 11 returns carry OR zero, code 14 returns sign XOR overflow, and code 15 returns (sign XOR overflow) OR zero. Codes 27, 30 and 31 return their exact inverses.
- R8: Codes 4, 5, 6, 20, 21 and 22 drive `illegal_o` to 1 and `pred_o` to 1. Every other code drives `illegal_o` to 0.
- R9: Flag word bits other than 0, 2, 6, 7, 11, 12 and 13 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flags_i | input | FLAG_W (16) | Flag word |
| code_i | input | 5 | Condition selector; bit 4 picks the inverted half |
| pred_o | output | 1 | Registered predicate |
| illegal_o | output | 1 | Registered reserved-code indication |

## Verification
The bench builds the block with its default parameters: a 16-bit flag word, with the seven tested flags at bits 0, 2, 6, 7, 11, 12 and 13. This setting makes a complete sweep possible. The sweep covers all 32 selectors against all 128 combinations of the seven tested flags, and the nine untested bits are filled with random values on each cycle. Every case is compared with a predicate that the bench computes directly from the code definitions. Reset and single-cycle latency are checked separately around the sweep.

// File: rtl/cond_test_pkg.sv
package cond_test_pkg;
  localparam int unsigned CODE_W = 5;
  localparam int unsigned SEL_W  = CODE_W - 1;

  typedef enum logic [SEL_W-1:0] {
    CT_ALWAYS      = 4'd0,
    CT_XCARRY      = 4'd1,
    CT_XZERO       = 4'd2,
    CT_NOT_STR_HIT = 4'd3,
    CT_RSV_A       = 4'd4,
    CT_RSV_B       = 4'd5,
    CT_RSV_C       = 4'd6,
    CT_STR_HIT     = 4'd7,
    CT_OVF         = 4'd8,
    CT_CARRY       = 4'd9,
    CT_ZERO        = 4'd10,
    CT_BELOW_EQ    = 4'd11,
    CT_SIGN        = 4'd12,
    CT_PARITY      = 4'd13,
    CT_LESS        = 4'd14,
    CT_LESS_EQ     = 4'd15
  } base_test_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic zf;
    logic sf;
    logic of;
    logic xcf;
    logic xzf;
  } flag_set_t;
endpackage

// File: rtl/cond_flag_pick.sv
module cond_flag_pick
  import cond_test_pkg::*;
#(
  parameter int unsigned FLAG_W  = 16,
  parameter int unsigned POS_CF  = 0,
  parameter int unsigned POS_PF  = 2,
  parameter int unsigned POS_ZF  = 6,
  parameter int unsigned POS_SF  = 7,
  parameter int unsigned POS_OF  = 11,
  parameter int unsigned POS_XCF = 12,
  parameter int unsigned POS_XZF = 13
) (
  input  logic [FLAG_W-1:0] flags_i,
  output flag_set_t         fl_o
);
  always_comb begin
    fl_o.cf  = flags_i[POS_CF];
    fl_o.pf  = flags_i[POS_PF];
    fl_o.zf  = flags_i[POS_ZF];
    fl_o.sf  = flags_i[POS_SF];
    fl_o.of  = flags_i[POS_OF];
    fl_o.xcf = flags_i[POS_XCF];
    fl_o.xzf = flags_i[POS_XZF];
  end
endmodule

// File: rtl/cond_base_eval.sv
module cond_base_eval
  import cond_test_pkg::*;
(
  input  base_test_e sel_i,
  input  flag_set_t  fl_i,
  output logic       val_o,
  output logic       rsv_o
);
  logic str_hit;
  logic lt;

  always_comb begin
    str_hit = ~fl_i.xzf & fl_i.zf;
    lt      = fl_i.sf ^ fl_i.of;
    rsv_o   = 1'b0;
    unique case (sel_i)
      CT_ALWAYS:      val_o = 1'b1;
      CT_XCARRY:      val_o = fl_i.xcf;
      CT_XZERO:       val_o = fl_i.xzf;
      CT_NOT_STR_HIT: val_o = ~str_hit;
      CT_STR_HIT:     val_o = str_hit;
      CT_OVF:         val_o = fl_i.of;
      CT_CARRY:       val_o = fl_i.cf;
      CT_ZERO:        val_o = fl_i.zf;
      CT_BELOW_EQ:    val_o = fl_i.cf | fl_i.zf;
      CT_SIGN:        val_o = fl_i.sf;
      CT_PARITY:      val_o = fl_i.pf;
      CT_LESS:        val_o = lt;
      CT_LESS_EQ:     val_o = lt | fl_i.zf;
      default: begin
        val_o = 1'b0;
        rsv_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/cond_test_eval.sv
module cond_test_eval
  import cond_test_pkg::*;
#(
  parameter int unsigned FLAG_W  = 16,
  parameter int unsigned POS_CF  = 0,
  parameter int unsigned POS_PF  = 2,
  parameter int unsigned POS_ZF  = 6,
  parameter int unsigned POS_SF  = 7,
  parameter int unsigned POS_OF  = 11,
  parameter int unsigned POS_XCF = 12,
  parameter int unsigned POS_XZF = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pred_o,
  output logic              illegal_o
);
  flag_set_t  fl;
  base_test_e sel;
  logic       upper;
  logic       base_val;
  logic       rsv;
  logic       pred_d;
  logic       pred_q;
  logic       illegal_q;

  assign sel   = base_test_e'(code_i[SEL_W-1:0]);
  assign upper = code_i[CODE_W-1];

  cond_flag_pick #(
    .FLAG_W(FLAG_W), .POS_CF(POS_CF), .POS_PF(POS_PF), .POS_ZF(POS_ZF),
    .POS_SF(POS_SF), .POS_OF(POS_OF), .POS_XCF(POS_XCF), .POS_XZF(POS_XZF)
  ) pick_i (
    .flags_i (flags_i),
    .fl_o    (fl)
  );

  cond_base_eval base_i (
    .sel_i (sel),
    .fl_i  (fl),
    .val_o (base_val),
    .rsv_o (rsv)
  );

  // Upper half inverts, except the string-end slot, which has its own test.
  always_comb begin
    if (rsv)
      pred_d = 1'b1;
    else if (upper && sel == CT_STR_HIT)
      pred_d = ~fl.xzf & ~fl.zf;
    else
      pred_d = base_val ^ upper;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      pred_q    <= pred_d;
      illegal_q <= rsv;
    end
  end

  assign pred_o    = pred_q;
  assign illegal_o = illegal_q;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!pred_o && !illegal_o));
  a_r8_illegal_pred: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> pred_o);
  a_r8_rsv_code: assert property (@(posedge clk) disable iff (rst)
    (code_i == 5'd20) |=> illegal_o);
  a_r3_always: assert property (@(posedge clk) disable iff (rst)
    (code_i == 5'd0) |=> (pred_o && !illegal_o));
  a_r3_never: assert property (@(posedge clk) disable iff (rst)
    (code_i == 5'd16) |=> !pred_o);
  a_r6_str_end: assert property (@(posedge clk) disable iff (rst)
    (code_i == 5'd23 && !flags_i[POS_ZF] && !flags_i[POS_XZF]) |=> pred_o);
  a_r4_carry: assert property (@(posedge clk) disable iff (rst)
    (code_i == 5'd9) |=> (pred_o == $past(flags_i[POS_CF])));
endmodule

// File: tb/cond_test_eval_tb_top.sv
`timescale 1ns/1ps
module cond_test_eval_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] flags = '0;
  logic [4:0]  code = '0;
  logic        pred;
  logic        illegal;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cond_test_eval dut_i (
    .clk(clk), .rst(rst), .flags_i(flags), .code_i(code),
    .pred_o(pred), .illegal_o(illegal)
  );

  function automatic bit is_rsv(input logic [4:0] c);
    return (c == 4 || c == 5 || c == 6 || c == 20 || c == 21 || c == 22);
  endfunction

  function automatic bit model(input logic [4:0] c, input logic [15:0] f);
    bit cf = f[0], pf = f[2], zf = f[6], sf = f[7], of_ = f[11];
    bit xc = f[12], xz = f[13];
    case (c)
      0: return 1;       16: return 0;
      1: return xc;      17: return !xc;
      2: return xz;      18: return !xz;
      3: return !(!xz && zf); 19: return !xz && zf;
      7: return !xz && zf;    23: return !xz && !zf;
      8: return of_;     24: return !of_;
      9: return cf;      25: return !cf;
      10: return zf;     26: return !zf;
      11: return cf || zf;    27: return !(cf || zf);
      12: return sf;     28: return !sf;
      13: return pf;     29: return !pf;
      14: return sf ^ of_;    30: return !(sf ^ of_);
      15: return (sf ^ of_) || zf; 31: return !((sf ^ of_) || zf);
      default: return 1;
    endcase
  endfunction

  function automatic string tag(input logic [4:0] c);
    case (c[3:0])
      0: return "R3";
      1, 2, 8, 9, 10, 12, 13: return "R4";
      3: return "R5";
      4, 5, 6: return "R8";
      7: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (code %0d flags %h)",
               req, what, act, exp, code, flags);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", pred, 1'b0, "pred after reset");
    check("R1", illegal, 1'b0, "illegal after reset");
    rst = 1'b0;
    // R2: one register stage
    code = 5'd0;
    @(posedge clk); #2;
    check("R2", pred, 1'b1, "pred one edge after code 0");
    @(negedge clk);
    code = 5'd16;
    #2;
    check("R2", pred, 1'b1, "pred holds before edge");
    @(negedge clk);
    check("R2", pred, 1'b0, "pred after code 16");
    // Exhaustive sweep; random untested bits cover R9
    for (int c = 0; c < 32; c++) begin
      for (int k = 0; k < 128; k++) begin
        logic [15:0] f;
        f = 16'($urandom);
        f[0] = k[0]; f[2] = k[1]; f[6] = k[2]; f[7] = k[3];
        f[11] = k[4]; f[12] = k[5]; f[13] = k[6];
        code = 5'(c);
        flags = f;
        @(negedge clk);
        check(tag(code), pred, model(code, flags), "predicate");
        check("R8", illegal, is_rsv(code), "illegal");
      end
    end
    // R9: untested bits all ones vs all zeros, same tested flags
    for (int c = 0; c < 32; c++) begin
      logic p0;
      code = 5'(c);
      flags = 16'h0000;
      @(negedge clk);
      p0 = pred;
      flags = 16'hC73A & 16'hC73A;
      flags = 16'b1100_0111_0011_1010;
      @(negedge clk);
      check("R9", pred, p0, "untested bits toggled");
    end
    // R1: reset mid-run
    code = 5'd4;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", pred, 1'b0, "pred after mid reset");
    check("R1", illegal, 1'b0, "illegal after mid reset");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule